// File: doc/BRIEF.md
# Sub-blocked Direct-Mapped Read Cache

This block is a read-only, direct-mapped cache in which every line holds one shared address tag and several word-sized sub-blocks. Each sub-block keeps its own presence bit. A lookup only counts as a hit when the stored tag for the line matches and the addressed sub-block is present. On a miss the cache asks the memory side for exactly one sub-block. It does not fetch the whole line, so the miss costs a single memory transfer.

When the stored tag differs from the requested one, the line is taken over by the new tag. At that moment every presence bit of the line is cleared, and then the single requested word is filled. When the tag already matches and only the sub-block is absent, the tag stays and only that one word is fetched. The CPU side accepts one request at a time. The fetched word goes back to the CPU in the cycle after memory acknowledges it.

Address layout with the default parameters (byte addresses, 32-bit words):
- bits [1:0] are the byte offset and are ignored;
- bits [3:2] select the sub-block;
- bits [7:4] select the line;
- bits [31:8] are the tag.

Top module: `sbc_cache`

## Requirements
- R1: After reset every sub-block of every line is absent. The first access to any address therefore misses. Directly after reset, `cpu_rdy_o` and `mem_req_o` are both low.
- R2: A request sampled at a clock edge while the block is idle is a hit when the line's tag matches and the sub-block is present. On a hit, `cpu_rdy_o` is high for exactly one cycle after the second edge, `cpu_data_o` carries the stored word, and `mem_req_o` stays low.
- R3: When the tag matches but the sub-block is absent, the block raises `mem_req_o` after the second edge for that one sub-block only. The tag is kept, so sub-blocks of the line that were present before still hit afterwards.
- R4: When the tag does not match, the new tag is installed and all sub-blocks of the line become absent before the requested word is filled. Words that were present under the old tag then miss, and so do the other words under the new tag.
- R5: While `mem_req_o` is high, `cpu_rdy_o` is low. The edge at which `mem_ack_i` is high ends the fill: on the next cycle `cpu_rdy_o` is high and `cpu_data_o` equals the `mem_data_i` value sampled at that edge. After the fill, that word hits with the same value.
- R6: Once raised, `mem_req_o` stays high and `mem_addr_o` stays unchanged until an edge at which `mem_ack_i` is high.
- R7: A `cpu_req_i` that arrives while a lookup or a fill is in progress is ignored. It produces no extra `cpu_rdy_o` pulse and no memory request.
- R8: `mem_addr_o` is the request address with its byte-offset bits forced to zero, i.e. tag, line and sub-block fields unchanged. Each miss produces exactly one acknowledged transfer, after which `mem_req_o` drops.
- R9: Lines are independent. A fill or a tag change in one line (address bits [7:4]) does not change the hit or miss outcome of any other line.
- R10: The byte-offset bits [1:0] of `cpu_addr_i` do not affect the hit or miss outcome or the data returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Read request, sampled while idle |
| cpu_addr_i | input | ADDR_W | Byte address of the read |
| cpu_rdy_o | output | 1 | One-cycle pulse: `cpu_data_o` holds the result |
| cpu_data_o | output | DATA_W | Read data |
| mem_req_o | output | 1 | Fill request for one sub-block, held until acknowledged |
| mem_addr_o | output | ADDR_W | Word-aligned address of the sub-block to fetch |
| mem_ack_i | input | 1 | Memory acknowledge, with data valid in the same cycle |
| mem_data_i | input | DATA_W | Fill word from memory |

## Verification
A wrong presence bit or a stale tag shows up at the next access to that line, two edges after the request is sampled. It appears either as a `mem_req_o` where a hit was due, or as a `cpu_rdy_o` pulse where a fill was due. A corrupted stored word shows up in `cpu_data_o` on the first hit to it. The bench keeps a separate model of tags and presence bits. It runs conflict, partial-line and offset patterns so that every kind of state error turns into a port difference within a few accesses.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   // Controller phases of one request.
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOOKUP = 2'd1,
      ST_FILL   = 2'd2
   } sbc_state_e;

   // Default geometry.
   localparam int unsigned DEF_ADDR_W = 32;
   localparam int unsigned DEF_DATA_W = 32;
   localparam int unsigned DEF_LINES  = 16;
   localparam int unsigned DEF_SUBS   = 4;

endpackage

// File: rtl/sbc_tag_store.sv
module sbc_tag_store #(
   parameter int unsigned LINES = 16,
   parameter int unsigned SUBS  = 4,
   parameter int unsigned TAG_W = 24,
   localparam int unsigned IDX_W = $clog2(LINES),
   localparam int unsigned SUB_W = $clog2(SUBS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [IDX_W-1:0] line_i,
   input  logic [SUB_W-1:0] sub_i,
   input  logic [TAG_W-1:0] tag_i,
   input  logic             install_i,
   input  logic             fill_i,
   output logic             tag_hit_o,
   output logic             sub_vld_o
);

   logic [TAG_W-1:0] tag_all [LINES];
   logic [SUBS-1:0]  vld_all [LINES];

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [TAG_W-1:0] tag_r;
      logic [SUBS-1:0]  vld_r;
      logic             sel;

      assign sel = (line_i == IDX_W'(l));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            tag_r <= '0;
            vld_r <= '0;
         end else if (sel) begin
            if (install_i) begin
               // new owner: every word of the line becomes absent
               tag_r <= tag_i;
               vld_r <= '0;
            end else if (fill_i) begin
               vld_r[sub_i] <= 1'b1;
            end
         end
      end

      assign tag_all[l] = tag_r;
      assign vld_all[l] = vld_r;
   end

   assign tag_hit_o = (tag_all[line_i] == tag_i);
   assign sub_vld_o = vld_all[line_i][sub_i];

endmodule

// File: rtl/sbc_data_store.sv
module sbc_data_store #(
   parameter int unsigned WORDS      = 64,
   parameter int unsigned DATA_W     = 32,
   parameter bit          DATA_RESET = 1'b0,
   localparam int unsigned SEL_W = $clog2(WORDS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o
);

   logic [DATA_W-1:0] word_all [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_r;
      logic              we;

      assign we = wr_en_i && (sel_i == SEL_W'(w));

      if (DATA_RESET) begin : g_rst
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)  word_r <= '0;
            else if (we)  word_r <= wr_data_i;
         end
      end else begin : g_norst
         logic unused_rst;
         assign unused_rst = rst_ni;
         always_ff @(posedge clk_i) begin
            if (we) word_r <= wr_data_i;
         end
      end

      assign word_all[w] = word_r;
   end

   assign rd_data_o = word_all[sel_i];

endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
   import sbc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LINES  = 16,
   parameter int unsigned SUBS   = 4,
   localparam int unsigned OFF_W = $clog2(DATA_W / 8),
   localparam int unsigned SUB_W = $clog2(SUBS),
   localparam int unsigned IDX_W = $clog2(LINES),
   localparam int unsigned WA_W  = ADDR_W - OFF_W,
   localparam int unsigned TAG_W = WA_W - SUB_W - IDX_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cpu_req_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   output logic              cpu_rdy_o,
   output logic [DATA_W-1:0] cpu_data_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [IDX_W-1:0]  lk_line_o,
   output logic [SUB_W-1:0]  lk_sub_o,
   output logic [TAG_W-1:0]  lk_tag_o,
   input  logic              lk_tag_hit_i,
   input  logic              lk_sub_vld_i,
   input  logic [DATA_W-1:0] lk_data_i,
   output logic              install_o,
   output logic              fill_o
);

   sbc_state_e        st_q;
   logic [WA_W-1:0]   waddr_q;
   logic              rdy_q;
   logic [DATA_W-1:0] data_q;
   logic              hit;
   logic              unused_offset;

   // byte offset never selects anything in a word-wide cache
   assign unused_offset = ^cpu_addr_i[OFF_W-1:0];

   assign lk_sub_o  = waddr_q[SUB_W-1:0];
   assign lk_line_o = waddr_q[SUB_W +: IDX_W];
   assign lk_tag_o  = waddr_q[SUB_W + IDX_W +: TAG_W];

   assign hit = lk_tag_hit_i && lk_sub_vld_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= ST_IDLE;
         waddr_q <= '0;
         rdy_q   <= 1'b0;
         data_q  <= '0;
      end else begin
         rdy_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (cpu_req_i) begin
                  waddr_q <= cpu_addr_i[ADDR_W-1:OFF_W];
                  st_q    <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               if (hit) begin
                  rdy_q  <= 1'b1;
                  data_q <= lk_data_i;
                  st_q   <= ST_IDLE;
               end else begin
                  st_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_ack_i) begin
                  rdy_q  <= 1'b1;
                  data_q <= mem_data_i;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // A tag change is installed on the lookup edge; the word lands on the ack edge.
   assign install_o  = (st_q == ST_LOOKUP) && !lk_tag_hit_i;
   assign fill_o     = (st_q == ST_FILL) && mem_ack_i;
   assign mem_req_o  = (st_q == ST_FILL);
   assign mem_addr_o = {waddr_q, {OFF_W{1'b0}}};
   assign cpu_rdy_o  = rdy_q;
   assign cpu_data_o = data_q;

endmodule

// File: rtl/sbc_cache.sv
module sbc_cache
   import sbc_pkg::*;
#(
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned DATA_W     = DEF_DATA_W,
   parameter int unsigned LINES      = DEF_LINES,
   parameter int unsigned SUBS       = DEF_SUBS,
   parameter bit          DATA_RESET = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cpu_req_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   output logic              cpu_rdy_o,
   output logic [DATA_W-1:0] cpu_data_o,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_data_i
);

   localparam int unsigned OFF_W = $clog2(DATA_W / 8);
   localparam int unsigned SUB_W = $clog2(SUBS);
   localparam int unsigned IDX_W = $clog2(LINES);
   localparam int unsigned TAG_W = ADDR_W - OFF_W - SUB_W - IDX_W;
   localparam int unsigned WORDS = LINES * SUBS;

   // elaboration-time parameter checks
   if (SUBS < 2 || (SUBS & (SUBS - 1)) != 0) begin : g_bad_subs
      $error("SUBS must be a power of two of at least 2");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 16");
   end
   if (ADDR_W <= OFF_W + SUB_W + IDX_W) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   logic [IDX_W-1:0]  lk_line;
   logic [SUB_W-1:0]  lk_sub;
   logic [TAG_W-1:0]  lk_tag;
   logic              tag_hit;
   logic              sub_vld;
   logic [DATA_W-1:0] rd_data;
   logic              install;
   logic              fill;

   sbc_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .SUBS(SUBS)
   ) u_ctrl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cpu_req_i    (cpu_req_i),
      .cpu_addr_i   (cpu_addr_i),
      .cpu_rdy_o    (cpu_rdy_o),
      .cpu_data_o   (cpu_data_o),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .mem_ack_i    (mem_ack_i),
      .mem_data_i   (mem_data_i),
      .lk_line_o    (lk_line),
      .lk_sub_o     (lk_sub),
      .lk_tag_o     (lk_tag),
      .lk_tag_hit_i (tag_hit),
      .lk_sub_vld_i (sub_vld),
      .lk_data_i    (rd_data),
      .install_o    (install),
      .fill_o       (fill)
   );

   sbc_tag_store #(
      .LINES(LINES), .SUBS(SUBS), .TAG_W(TAG_W)
   ) u_tags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .line_i    (lk_line),
      .sub_i     (lk_sub),
      .tag_i     (lk_tag),
      .install_i (install),
      .fill_i    (fill),
      .tag_hit_o (tag_hit),
      .sub_vld_o (sub_vld)
   );

   sbc_data_store #(
      .WORDS(WORDS), .DATA_W(DATA_W), .DATA_RESET(DATA_RESET)
   ) u_data (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_i     ({lk_line, lk_sub}),
      .wr_en_i   (fill),
      .wr_data_i (mem_data_i),
      .rd_data_o (rd_data)
   );

endmodule

// File: rtl/sbc_cache_chk.sv
module sbc_cache_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned OFF_W = $clog2(DATA_W / 8)
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cpu_rdy_o,
   input logic [DATA_W-1:0] cpu_data_o,
   input logic              mem_req_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_ack_i,
   input logic [DATA_W-1:0] mem_data_i
);

   p_rdy_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_rdy_o |=> !cpu_rdy_o);

   p_fill_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && mem_ack_i) |=> (cpu_rdy_o && (cpu_data_o == $past(mem_data_i))));

   p_quiet_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> !cpu_rdy_o);

   p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

   p_addr_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> (mem_addr_o[OFF_W-1:0] == '0));

   p_one_xfer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && mem_ack_i) |=> !mem_req_o);

endmodule

bind sbc_cache sbc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cpu_rdy_o  (cpu_rdy_o),
   .cpu_data_o (cpu_data_o),
   .mem_req_o  (mem_req_o),
   .mem_addr_o (mem_addr_o),
   .mem_ack_i  (mem_ack_i),
   .mem_data_i (mem_data_i)
);

// File: tb/sbc_cache_tb.sv
module sbc_cache_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic        cpu_rdy;
   logic [31:0] cpu_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_data = '0;

   int n_vec = 0;
   int n_bad = 0;

   logic [23:0] ref_tag [16];
   logic [3:0]  ref_vld [16];

   always #(CLK_PERIOD / 2) clk = ~clk;

   sbc_cache u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .cpu_req_i  (cpu_req),
      .cpu_addr_i (cpu_addr),
      .cpu_rdy_o  (cpu_rdy),
      .cpu_data_o (cpu_data),
      .mem_req_o  (mem_req),
      .mem_addr_o (mem_addr),
      .mem_ack_i  (mem_ack),
      .mem_data_i (mem_data)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [31:0] mk_addr(input logic [23:0] t, input logic [3:0] l,
                                           input logic [1:0] s, input logic [1:0] o);
      return {t, l, s, o};
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // One read; poke drives a second request during the busy phase (R7).
   task automatic access(input logic [31:0] a, input bit poke, input string rq_in);
      logic [3:0]  l;
      logic [1:0]  s;
      logic [23:0] t;
      bit          exp_hit;
      logic [31:0] exp_data;
      logic [31:0] wa;
      string       rq;
      int          dly;
      t  = a[31:8];
      l  = a[7:4];
      s  = a[3:2];
      wa = {a[31:2], 2'b00};
      exp_hit  = ref_vld[l][s] && (ref_tag[l] == t);
      exp_data = mem_word(wa);
      if (rq_in != "") rq = rq_in;
      else if (exp_hit) rq = "R2";
      else if (ref_tag[l] == t) rq = "R3";
      else rq = "R4";

      @(negedge clk);
      cpu_req  = 1'b1;
      cpu_addr = a;
      @(negedge clk);
      cpu_req = 1'b0;
      if (poke) begin
         cpu_req  = 1'b1;
         cpu_addr = a ^ 32'h0000_0F3C;
      end
      check(!cpu_rdy && !mem_req, rq, "quiet during lookup", {30'd0, cpu_rdy, mem_req}, 32'd0);
      @(negedge clk);
      cpu_req = 1'b0;
      if (exp_hit) begin
         check(cpu_rdy && !mem_req, rq, "hit rdy/no mem req", {30'd0, cpu_rdy, mem_req}, 32'd2);
         check(cpu_data == exp_data, rq, "hit data", cpu_data, exp_data);
      end else begin
         check(mem_req && !cpu_rdy, rq, "miss raises mem req", {30'd0, cpu_rdy, mem_req}, 32'd1);
         check(mem_addr == wa, "R8", "fill address", mem_addr, wa);
         dly = $urandom_range(0, 3);
         for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            check(mem_req && mem_addr == wa, "R6", "request held", mem_addr, wa);
         end
         mem_ack  = 1'b1;
         mem_data = exp_data;
         @(negedge clk);
         mem_ack  = 1'b0;
         mem_data = 32'hDEAD_BEEF;
         check(cpu_rdy && !mem_req, "R5", "rdy after ack", {30'd0, cpu_rdy, mem_req}, 32'd2);
         check(cpu_data == exp_data, "R5", "fill data", cpu_data, exp_data);
         if (ref_tag[l] != t) begin
            ref_tag[l] = t;
            ref_vld[l] = '0;
         end
         ref_vld[l][s] = 1'b1;
      end
      @(negedge clk);
      check(!cpu_rdy, "R2", "single rdy pulse", {31'd0, cpu_rdy}, 32'd0);
      if (poke) begin
         for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!cpu_rdy && !mem_req, "R7", "busy request ignored",
                  {30'd0, cpu_rdy, mem_req}, 32'd0);
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R5 watchdog expired act=running exp=done");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         ref_tag[i] = '0;
         ref_vld[i] = '0;
      end
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!cpu_rdy && !mem_req, "R1", "reset outputs", {30'd0, cpu_rdy, mem_req}, 32'd0);

      // cold miss, then hit
      access(mk_addr(24'h12, 4'd3, 2'd0, 2'd0), 1'b0, "R1");
      access(mk_addr(24'h12, 4'd3, 2'd0, 2'd0), 1'b0, "R2");
      // same tag, absent word: partial fill, tag kept
      access(mk_addr(24'h12, 4'd3, 2'd1, 2'd0), 1'b0, "R3");
      access(mk_addr(24'h12, 4'd3, 2'd0, 2'd0), 1'b0, "R3");
      access(mk_addr(24'h12, 4'd3, 2'd1, 2'd0), 1'b0, "R3");
      // byte offset ignored
      access(mk_addr(24'h12, 4'd3, 2'd0, 2'd3), 1'b0, "R10");
      access(mk_addr(24'h12, 4'd3, 2'd1, 2'd2), 1'b0, "R10");
      // other line, then first line unaffected
      access(mk_addr(24'h12, 4'd4, 2'd0, 2'd0), 1'b0, "R9");
      access(mk_addr(24'h77, 4'd4, 2'd2, 2'd0), 1'b0, "R9");
      access(mk_addr(24'h12, 4'd3, 2'd1, 2'd0), 1'b0, "R9");
      // conflict: new tag clears the line
      access(mk_addr(24'h56, 4'd3, 2'd0, 2'd0), 1'b0, "R4");
      access(mk_addr(24'h56, 4'd3, 2'd1, 2'd0), 1'b0, "R4");
      access(mk_addr(24'h12, 4'd3, 2'd1, 2'd0), 1'b0, "R4");
      access(mk_addr(24'h12, 4'd3, 2'd0, 2'd0), 1'b0, "R4");
      // requests during busy phases
      access(mk_addr(24'h99, 4'd9, 2'd3, 2'd0), 1'b1, "R7");
      access(mk_addr(24'h99, 4'd9, 2'd3, 2'd1), 1'b1, "R7");

      // constrained random traffic over a small tag pool
      for (int k = 0; k < 600; k++) begin
         logic [23:0] t;
         logic [3:0]  l;
         logic [1:0]  s;
         logic [1:0]  o;
         t = 24'($urandom_range(0, 2)) + 24'h40;
         l = 4'($urandom_range(0, 15));
         s = 2'($urandom_range(0, 3));
         o = 2'($urandom_range(0, 3));
         access(mk_addr(t, l, s, o), ($urandom_range(0, 9) == 0), "");
      end

      summary();
      $finish;
   end

endmodule